// File: doc/BRIEF.md
# Bus Stuck-Clock and Idle Watchdog

This block sits beside a two-wire serial client engine and watches the clock and data lines, which have already been synchronized to a free-running system clock. It keeps two timers in system clock cycles, and their lengths come from parameters: the clock frequency in hertz and each limit in microseconds. The first timer measures how long the clock line has stayed low. The second measures how long both lines have stayed high while the engine reports an open transaction. When either timer expires, the block gives the engine a reset pulse that lasts one cycle.

A single enable input gates both timers. A configuration bit drives this input, and that bit is clear after reset. While the enable is low the block never produces a reset, so the bus then behaves as plain I2C without any timeout. A two-bit cause output holds the reason for the most recent pulse until the next pulse replaces it.

Top module: `sm_bus_watchdog`

## Requirements
- R1: While enabled, if the clock line is sampled low on LOW_CYC consecutive cycles (LOW_CYC = CLK_HZ × LOW_US / 10^6), `bus_rst_o` goes high for one cycle in the cycle after the LOW_CYC-th such sample.
- R2: While enabled, if clock high, data high and `busy_i` high are all sampled together on more than IDLE_CYC consecutive cycles (IDLE_CYC = CLK_HZ × IDLE_US / 10^6), one pulse follows the (IDLE_CYC+1)-th such sample.
- R3: While `en_i` is low, `bus_rst_o` stays low whatever the bus does. Sampling `en_i` low also clears both timers.
- R4: Any sample that breaks a condition restarts that timer, so a full new run of samples is needed before it can expire.
- R5: A condition that is held past expiry produces only one pulse. No further pulse comes until that condition has been broken.
- R6: The idle timer only runs while `busy_i` is high. With `busy_i` low, lines that stay high never cause a pulse.
- R7: `cause_o` is 2'b00 after reset. One cycle after a pulse it becomes 2'b01 if the clock-low timer caused the pulse, or 2'b10 if the idle timer caused it. It then holds that value until the next pulse.
- R8: While `rst_n` is sampled low, `bus_rst_o` and `cause_o` are 0 and both timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Timeout enable from configuration |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| busy_i | input | 1 | Engine is inside a transaction |
| bus_rst_o | output | 1 | One-cycle reset pulse to the engine |
| cause_o | output | 2 | Source of last pulse: bit 0 clock-low, bit 1 idle |

## Verification
A pulse comes out exactly one cycle after the clock edge that takes the last sample needed to expire a timer. The cause code then changes one cycle after the pulse. The reference model in the bench updates on the same rising edge that the design samples. The bench compares against the model at the following falling edge, so both the pulse and the delayed cause change are checked in the exact cycle they are due. Directed checks count the pulses seen over each stimulus window, which covers the restart after one breaking cycle, expiry in the same cycle, and the disabled cases.

// File: rtl/sm_watchdog_pkg.sv
// Package for the bus watchdog: cause codes and the helper that turns
// microseconds into clock cycles.
// Assumes CLK_HZ * us fits in a longint.
package sm_watchdog_pkg;

    localparam int NUM_COND = 2;  // 0: clock held low, 1: idle while busy

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_LOW  = 2'b01,
        CAUSE_IDLE = 2'b10
    } cause_e;

    // Convert a duration in microseconds to a whole number of clock cycles.
    function automatic int us_to_cycles(input longint clk_hz, input longint us);
        longint c;
        c = (clk_hz * us) / 64'd1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/sm_expiry_timer.sv
// sm_expiry_timer: counts consecutive cycles on which cond_i is high.
// fire_o goes high for one cycle after the LIMIT-th consecutive sample.
// The timer then disarms and stays quiet until cond_i is seen low.
// Assumes LIMIT >= 1.
module sm_expiry_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic fire_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Run length counter with a one-shot expiry that rearms only after a break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            fire_o  <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (!cond_i) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
            end else if (armed_q) begin
                if (cnt_q == LAST) begin
                    fire_o  <= 1'b1;
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sm_cause_reg.sv
// sm_cause_reg: latches the vector of timer expiries whenever any of them
// fires, so the cause of the last reset stays visible.
// Assumes at most one expiry per cycle. The two conditions are exclusive.
module sm_cause_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire_i,
    output logic [N-1:0] cause_o
);
    // Capture the source of each expiry and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_o <= '0;
        else if (|fire_i) cause_o <= fire_i;
    end
endmodule

// File: rtl/sm_bus_watchdog.sv
// sm_bus_watchdog: stuck-clock and idle watchdog for a two-wire client engine.
// It builds one gated condition per timer and runs one expiry timer for each.
// The expiries are ORed into a single reset pulse, and the cause is latched.
// Assumes scl_i and sda_i are already synchronized to clk.
module sm_bus_watchdog
    import sm_watchdog_pkg::*;
#(
    parameter longint CLK_HZ  = 50000000,
    parameter longint LOW_US  = 30000,
    parameter longint IDLE_US = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       busy_i,
    output logic       bus_rst_o,
    output logic [1:0] cause_o
);
    localparam int LOW_CYC  = us_to_cycles(CLK_HZ, LOW_US);
    localparam int IDLE_CYC = us_to_cycles(CLK_HZ, IDLE_US);

    logic [NUM_COND-1:0] cond;
    logic [NUM_COND-1:0] fire;

    // Gated conditions: the clock held low, or both lines high inside a transaction.
    always_comb begin
        cond[0] = en_i && !scl_i;
        cond[1] = en_i && scl_i && sda_i && busy_i;
    end

    // One timer per condition. The idle limit must be exceeded, not just met.
    for (genvar i = 0; i < NUM_COND; i++) begin : g_tmr
        localparam int LIM = (i == 0) ? LOW_CYC : IDLE_CYC + 1;
        sm_expiry_timer #(.LIMIT(LIM)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (cond[i]),
            .fire_o (fire[i])
        );
    end

    sm_cause_reg #(.N(NUM_COND)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .cause_o (cause_o)
    );

    // Either expiry resets the engine.
    always_comb bus_rst_o = |fire;
endmodule

// File: rtl/sm_bus_watchdog_chk.sv
// sm_bus_watchdog_chk: properties of the watchdog, checked at its ports.
// It is attached to every instance of the top module by the bind below.
module sm_bus_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       scl_i,
    input logic       sda_i,
    input logic       busy_i,
    input logic       bus_rst_o,
    input logic [1:0] cause_o
);
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |=> !bus_rst_o);                                         // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !bus_rst_o);                                             // R3
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));                                                // R7
    AST_IDLE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_o && $past(scl_i)) |-> $past(busy_i && sda_i));           // R6
    AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_o && !$past(scl_i)) |=> (cause_o == 2'b01));              // R1
    AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_o && $past(scl_i)) |=> (cause_o == 2'b10));               // R2
    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rst_o) && $past(rst_n) |-> $stable(cause_o));           // R7
endmodule

bind sm_bus_watchdog sm_bus_watchdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .busy_i    (busy_i),
    .bus_rst_o (bus_rst_o),
    .cause_o   (cause_o)
);

// File: tb/sim_sm_bus_watchdog.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is compared on every falling edge,
// and directed pulse counts are checked per scenario. For short runs the
// bench sets CLK_HZ to 1 MHz, so one cycle stands for one microsecond.
module sim_sm_bus_watchdog;
    localparam int LOWN  = 100;
    localparam int IDLEN = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, scl = 1'b1, sda = 1'b1, busy = 1'b0;
    logic bus_rst;
    logic [1:0] cause;

    int checks = 0, errors = 0, pulses = 0, cycles = 0;
    int lo_run = 0, id_run = 0;
    bit lo_done = 0, id_done = 0;
    bit exp_rst = 0;
    logic [1:0] exp_cause = 2'b00, pend = 2'b00;
    bit done = 0;

    always #2.5 clk = ~clk;

    sm_bus_watchdog #(.CLK_HZ(1000000), .LOW_US(LOWN), .IDLE_US(IDLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
        .busy_i(busy), .bus_rst_o(bus_rst), .cause_o(cause)
    );

    // Reference model: run lengths kept as integers, updated on each sample.
    always @(posedge clk) begin
        if (!rst_n) begin
            lo_run = 0; id_run = 0; lo_done = 0; id_done = 0;
            exp_rst = 0; exp_cause = 2'b00;
        end else begin
            if (exp_rst) exp_cause = pend;
            exp_rst = 0;
            if (en && !scl) begin
                if (!lo_done) begin
                    lo_run++;
                    if (lo_run == LOWN) begin exp_rst = 1; pend = 2'b01; lo_done = 1; lo_run = 0; end
                end
            end else begin lo_run = 0; lo_done = 0; end
            if (en && scl && sda && busy) begin
                if (!id_done) begin
                    id_run++;
                    if (id_run == IDLEN + 1) begin exp_rst = 1; pend = 2'b10; id_done = 1; id_run = 0; end
                end
            end else begin id_run = 0; id_done = 0; end
        end
    end

    // Compare with the model every cycle, away from the sampling edge.
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            checks += 2;
            if (bus_rst !== exp_rst) begin
                errors++;
                $display("FAIL R1 R2 R3 R8 pulse at cycle %0d: got %b expected %b", cycles, bus_rst, exp_rst);
            end
            if (cause !== exp_cause) begin
                errors++;
                $display("FAIL R7 cause at cycle %0d: got %b expected %b", cycles, cause, exp_cause);
            end
            if (bus_rst === 1'b1) pulses++;
        end
    end

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic expect_pulses(input string req, input int want);
        checks++;
        if (pulses != want) begin
            errors++;
            $display("FAIL %s pulse count: got %0d expected %0d", req, pulses, want);
        end
        pulses = 0;
    endtask

    task automatic summary();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait_cyc(4);
        checks++;                                           // R8 reset state
        if (bus_rst !== 1'b0 || cause !== 2'b00) begin
            errors++;
            $display("FAIL R8 reset outputs: got %b/%b expected 0/00", bus_rst, cause);
        end
        rst_n = 1'b1;
        pulses = 0;
        // R3: disabled, clock stuck low and idle while busy -> nothing.
        scl = 0; wait_cyc(3 * LOWN);
        scl = 1; busy = 1; wait_cyc(3 * IDLEN);
        expect_pulses("R3", 0);
        busy = 0; en = 1; wait_cyc(2);
        // R1 and R5: hold low well past expiry -> exactly one pulse.
        scl = 0; wait_cyc(3 * LOWN);
        scl = 1; wait_cyc(3);
        expect_pulses("R1 R5", 1);
        checks++;
        if (cause !== 2'b01) begin errors++; $display("FAIL R7 low cause: got %b expected 01", cause); end
        // R4: break one cycle short of expiry, then a full run is needed again.
        scl = 0; wait_cyc(LOWN - 1);
        scl = 1; wait_cyc(1);
        scl = 0; wait_cyc(LOWN - 1);
        expect_pulses("R4", 0);
        wait_cyc(2);
        expect_pulses("R4", 1);
        scl = 1; wait_cyc(2);
        // R6: idle lines without busy -> nothing.
        sda = 1; busy = 0; wait_cyc(4 * IDLEN);
        expect_pulses("R6", 0);
        // R2: exactly IDLEN samples do not fire, the next one does.
        busy = 1; wait_cyc(IDLEN);
        expect_pulses("R2", 0);
        wait_cyc(3 * IDLEN);
        expect_pulses("R2 R5", 1);
        checks++;
        if (cause !== 2'b10) begin errors++; $display("FAIL R7 idle cause: got %b expected 10", cause); end
        // R3: dropping enable mid-count clears the timer.
        busy = 0; wait_cyc(1); scl = 0; wait_cyc(LOWN - 5);
        en = 0; wait_cyc(1); en = 1; wait_cyc(LOWN - 5);
        expect_pulses("R3", 0);
        wait_cyc(10);
        expect_pulses("R1", 1);
        // R7: cause holds across a quiet stretch.
        scl = 1; wait_cyc(20);
        checks++;
        if (cause !== 2'b01) begin errors++; $display("FAIL R7 hold: got %b expected 01", cause); end
        // R8: reset mid-run clears state and the cause.
        scl = 0; wait_cyc(LOWN / 2);
        rst_n = 0; wait_cyc(2);
        checks++;
        if (cause !== 2'b00 || bus_rst !== 1'b0) begin
            errors++; $display("FAIL R8 mid reset: got %b/%b expected 0/00", bus_rst, cause);
        end
        rst_n = 1; pulses = 0; wait_cyc(LOWN - 1);
        expect_pulses("R8", 0);
        wait_cyc(2);
        expect_pulses("R8 R1", 1);
        summary();
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 50000);
        errors++; checks++;
        $display("FAIL watchdog expired: got timeout expected completion");
        summary();
    end
endmodule